// File: doc/BRIEF.md
# I2C EEPROM Sequential Read Controller

This block is a bit-level I2C master that fetches a run of bytes from a serial EEPROM, starting at word address zero. The host pulses `start_i` with a byte count. The block then checks that the data line is free and runs a dummy write that selects the device and loads address 0x00. It follows with a repeated start and a read select, and clocks the bytes in. Each byte appears on `data_o` with a one-cycle strobe. The transfer closes with a stop condition. `busy_o`, `done_o` and `err_o` report progress and outcome.

Both pads are open drain and their drive is inverted: a 1 on `scl_o` or `sda_o` pulls the wire low, and a 0 lets the pull-up raise it. The sensed data line `sda_i` carries the true wire level. It passes through a synchroniser before any decision uses it. A single phase timer of `CLK_DIV` system clocks, meant to be about 5 us, paces every edge and every settle delay.

The block recovers from a data line stuck low in two places. Before each start condition it issues released clock pulses. At the stop condition it retries the release. Each recovery gives up after ten tries and then raises the error flag.

Top module: `eeprom_seq_reader`

## Requirements
- R1: While `rst_ni` is low, `scl_o`, `sda_o`, `busy_o`, `done_o`, `err_o` and `data_valid_o` are all 0, so both wires are released.
- R2: A start with `count_i` = 0 sets `done_o` with `err_o` = 0 on the next cycle. It never raises `busy_o` and produces no SCL edge.
- R3: A transfer sends a start and the byte 0xA0, then the byte 0x00, then a repeated start and the byte 0xA1. It then reads `count_i` bytes from address 0 upward, MSB first. Each byte is presented on `data_o` with `data_valid_o` high for exactly one cycle. The transfer ends with `done_o` = 1 and `err_o` = 0.
- R4: A 1 on a drive output pulls its wire low and a 0 releases it. `sda_i` is read as the true wire level. A normal transfer shows exactly two start conditions and one stop condition on the wires.
- R5: Before each start, if SDA reads low the block issues released SCL pulses, at most ten of them, and stops as soon as SDA reads high. If SDA is still low after the tenth pulse, the block ends with `done_o` = 1 and `err_o` = 1 after exactly ten SCL falls and delivers no data.
- R6: After each of the three transmitted bytes, SDA is released for one clock and sampled. A high level aborts the transfer with `done_o` = 1, `err_o` = 1 and no data.
- R7: The master drives SDA low for one clock after every received byte except the last. After the last byte it leaves SDA released, which the device sees as a no-acknowledge.
- R8: The stop condition is one SCL pulse with SDA low, then SCL high, then SDA released, then SDA sampled after one phase. The sequence is tried up to ten times. If SDA succeeds within ten tries the result is success. If it is still low after ten tries, `err_o` = 1, with the data already delivered.
- R9: During bit transfers SCL is high for exactly `CLK_DIV` cycles and low for exactly 2·`CLK_DIV` cycles. The master changes SDA only while SCL is low, except for the start and stop edges.
- R10: `busy_o` rises on the cycle after an accepted start and falls when `done_o` rises. `done_o` and `err_o` hold until the next accepted start. A start pulse while busy is ignored.
- R11: One cycle after `busy_o` falls, both drive outputs are 0, whether the transfer succeeded or failed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (pulse, ignored while busy) |
| count_i | input | CNT_W | Number of bytes to read, sampled with start_i |
| sda_i | input | 1 | Sensed SDA wire level (true polarity) |
| scl_o | output | 1 | SCL pad drive, 1 pulls the wire low |
| sda_o | output | 1 | SDA pad drive, 1 pulls the wire low |
| data_o | output | 8 | Last received byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished, held until next start |
| err_o | output | 1 | Finished transfer failed, held until next start |

## Verification
A behavioural EEPROM model on open-drain wires answers the bus. The host side reads runs of 0, 1, 5 and 20 bytes, which separate the empty case, the single byte that gets only a no-acknowledge, and the ACK chain with address increment. The data line is held stuck before the start for 3, 10 and 11 pulses, and during the stop for 9 and 10 retries, so that both ten-try limits are checked on each side of the boundary. The device withholds its acknowledge after each of the three transmitted bytes in turn, and a second start pulse arrives mid-transfer to show it is ignored.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CHK, ST_RECOV, ST_STA, ST_TXB, ST_TXACK,
    ST_RXB, ST_MACK, ST_STP, ST_SREL
  } rd_state_e;

  typedef enum logic [1:0] {TX_CTRL_WR, TX_ADDR, TX_CTRL_RD} tx_kind_e;

  localparam logic [7:0] CTRL_WR   = 8'hA0;
  localparam logic [7:0] CTRL_RD   = 8'hA1;
  localparam logic [7:0] WORD_ADDR = 8'h00;
endpackage

// File: rtl/eeprom_rd_sync.sv
module eeprom_rd_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/eeprom_rd_phase_timer.sv
module eeprom_rd_phase_timer #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = run_i && (cnt == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt <= '0;
    else if (!run_i || tick_o)  cnt <= '0;
    else                        cnt <= cnt + 1'b1;
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
  import eeprom_rd_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 250,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned RETRY       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic [7:0]       data_o,
  output logic             data_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned TW = $clog2(RETRY + 1);
  localparam logic [TW-1:0] TRY_LIM  = TW'(RETRY);
  localparam logic [TW-1:0] TRY_STOP = TW'(RETRY - 1);

  rd_state_e        state_q;
  tx_kind_e         txk_q;
  logic [1:0]       ph_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q, data_q;
  logic [CNT_W-1:0] rem_q;
  logic [TW-1:0]    try_q;
  logic             rd_sel_q, done_q, err_q, valid_q;
  logic             scl_rel_q, sda_rel_q, scl_d, sda_d, pbit;
  logic             tick, sda_s, in_pulse, ph_last, pend, last_byte;

  eeprom_rd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  eeprom_rd_phase_timer #(.DIV(CLK_DIV)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q != ST_IDLE), .tick_o(tick));

  assign in_pulse  = state_q inside {ST_RECOV, ST_TXB, ST_TXACK, ST_RXB, ST_MACK, ST_STP};
  assign ph_last   = (ph_q == 2'd2);
  assign pend      = tick && ph_last;
  assign last_byte = (rem_q == CNT_W'(1));

  // line levels as "released" flags; pulse = low/hold, low/new, high/new
  always_comb begin
    scl_d = 1'b1;
    sda_d = 1'b1;
    case (state_q)
      ST_TXB:  pbit = sh_q[7];
      ST_MACK: pbit = last_byte;
      ST_STP:  pbit = 1'b0;
      default: pbit = 1'b1;
    endcase
    if (state_q == ST_CHK) begin
      scl_d = scl_rel_q;
      sda_d = sda_rel_q;
    end else if (state_q == ST_STA) begin
      sda_d = 1'b0;
    end else if (in_pulse) begin
      scl_d = ph_last;
      sda_d = (ph_q == 2'd0) ? sda_rel_q : pbit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      txk_q     <= TX_CTRL_WR;
      ph_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      data_q    <= '0;
      rem_q     <= '0;
      try_q     <= '0;
      rd_sel_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      valid_q   <= 1'b0;
      scl_rel_q <= 1'b1;
      sda_rel_q <= 1'b1;
    end else begin
      valid_q   <= 1'b0;
      scl_rel_q <= scl_d;
      sda_rel_q <= sda_d;
      if (tick && in_pulse && !ph_last) ph_q <= ph_q + 2'd1;
      case (state_q)
        ST_IDLE: if (start_i) begin
          done_q   <= (count_i == '0);
          err_q    <= 1'b0;
          rem_q    <= count_i;
          try_q    <= '0;
          rd_sel_q <= 1'b0;
          ph_q     <= '0;
          if (count_i != '0) state_q <= ST_CHK;
        end
        ST_CHK: if (tick) begin
          if (sda_s) begin
            state_q <= ST_STA;
            try_q   <= '0;
          end else if (try_q == TRY_LIM) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            state_q <= ST_RECOV;
            ph_q    <= '0;
            try_q   <= try_q + 1'b1;
          end
        end
        ST_RECOV: if (pend) begin
          state_q <= ST_CHK;
          ph_q    <= '0;
        end
        ST_STA: if (tick) begin
          state_q <= ST_TXB;
          ph_q    <= '0;
          bit_q   <= 3'd7;
          sh_q    <= rd_sel_q ? CTRL_RD : CTRL_WR;
          txk_q   <= rd_sel_q ? TX_CTRL_RD : TX_CTRL_WR;
        end
        ST_TXB: if (pend) begin
          ph_q <= '0;
          if (bit_q == 3'd0) state_q <= ST_TXACK;
          else begin
            bit_q <= bit_q - 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
        ST_TXACK: if (pend) begin
          ph_q <= '0;
          if (sda_s) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            case (txk_q)
              TX_CTRL_WR: begin
                state_q <= ST_TXB;
                sh_q    <= WORD_ADDR;
                bit_q   <= 3'd7;
                txk_q   <= TX_ADDR;
              end
              TX_ADDR: begin
                state_q  <= ST_CHK;
                rd_sel_q <= 1'b1;
                try_q    <= '0;
              end
              default: begin
                state_q <= ST_RXB;
                bit_q   <= 3'd7;
              end
            endcase
          end
        end
        ST_RXB: if (pend) begin
          ph_q <= '0;
          sh_q <= {sh_q[6:0], sda_s};
          if (bit_q == 3'd0) begin
            data_q  <= {sh_q[6:0], sda_s};
            valid_q <= 1'b1;
            state_q <= ST_MACK;
          end else bit_q <= bit_q - 3'd1;
        end
        ST_MACK: if (pend) begin
          ph_q <= '0;
          if (last_byte) begin
            state_q <= ST_STP;
            try_q   <= '0;
          end else begin
            rem_q   <= rem_q - 1'b1;
            state_q <= ST_RXB;
            bit_q   <= 3'd7;
          end
        end
        ST_STP: if (pend) begin
          ph_q    <= '0;
          state_q <= ST_SREL;
        end
        ST_SREL: if (tick) begin
          if (sda_s) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (try_q == TRY_STOP) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else begin
            try_q   <= try_q + 1'b1;
            state_q <= ST_STP;
            ph_q    <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_o        = ~scl_rel_q;
  assign sda_o        = ~sda_rel_q;
  assign data_o       = data_q;
  assign data_valid_o = valid_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             scl_o,
  input logic             sda_o,
  input logic             data_valid_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);
  a_r2_zero_count_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i == '0) |=> (done_o && !err_o && !busy_o));

  a_r10_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i != '0) |=> (busy_o && !done_o && !err_o));

  a_r10_busy_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  a_r10_err_has_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r3_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  a_r3_valid_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> busy_o);

  a_r11_release_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> (!scl_o && !sda_o));
endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
  .scl_o(scl_o), .sda_o(sda_o), .data_valid_o(data_valid_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

// File: tb/sim_eeprom_seq_reader.sv
module sim_eeprom_seq_reader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] count = '0;
  logic scl_drv, sda_drv, valid, busy, done, err;
  logic [7:0] data;
  logic slave_pull = 1'b0;
  int   jam = 0;
  wire  scl_ln = ~scl_drv;
  wire  sda_ln = ~(sda_drv | slave_pull | (jam > 0));

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_seq_reader #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count), .sda_i(sda_ln),
    .scl_o(scl_drv), .sda_o(sda_drv), .data_o(data), .data_valid_o(valid),
    .busy_o(busy), .done_o(done), .err_o(err));

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(int a);
    return 8'(a * 37 + 11);
  endfunction

  // ---------------- EEPROM model on the wires ----------------
  int bc = 0, ptr = 0, n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0, n_fall = 0;
  int nack_ctl = 0, stop_jam = 0, n_ctl_wr = 0, n_ctl_rd = 0, addr_seen = -1;
  logic [7:0] sh = '0;
  logic active = 0, rd_mode = 0, first = 0, go_read = 0, nacked = 0, arm = 0;
  logic prev_scl = 1, prev_sda = 1;

  always @(scl_ln or sda_ln) begin
    logic [7:0] mb;
    if (scl_ln && prev_scl && (sda_ln != prev_sda)) begin
      if (!sda_ln) begin
        n_start++; active = 1; bc = 0; first = 1; rd_mode = 0;
        go_read = 0; nacked = 0; slave_pull = 0;
      end else begin
        n_stop++; active = 0; rd_mode = 0; slave_pull = 0;
      end
    end else if (scl_ln && !prev_scl) begin
      if (active) begin
        if (!rd_mode) begin
          if (bc < 8) sh = {sh[6:0], sda_ln};
          bc++;
          if (bc == 9) bc = 0;
        end else begin
          bc++;
          if (bc == 8) ptr++;
          if (bc == 9) begin
            bc = 0;
            if (sda_ln) begin nacked = 1; n_mnack++; arm = 1; end
            else n_mack++;
          end
        end
      end
    end else if (!scl_ln && prev_scl) begin
      n_fall++;
      if (jam > 0) jam--;
      if (arm) begin jam = stop_jam; arm = 0; end
      if (active) begin
        if (!rd_mode) begin
          if (bc == 8) begin
            if (first) begin
              first = 0;
              if (sh == 8'hA0) begin n_ctl_wr++; slave_pull = (nack_ctl != 1); end
              else if (sh == 8'hA1) begin
                n_ctl_rd++; slave_pull = (nack_ctl != 3); go_read = slave_pull;
              end else slave_pull = 0;
            end else begin
              addr_seen = sh; ptr = sh; slave_pull = (nack_ctl != 2);
            end
          end else if (bc == 0) begin
            slave_pull = 0;
            if (go_read) begin
              rd_mode = 1; mb = mem_byte(ptr); slave_pull = !mb[7];
            end
          end
        end else begin
          mb = mem_byte(ptr);
          if (nacked || bc >= 8) slave_pull = 0;
          else slave_pull = !mb[7 - bc];
        end
      end
    end
    prev_scl = scl_ln;
    prev_sda = sda_ln;
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  bit busy_seen = 0;
  int run_len = 0, min_hi = 1 << 30, min_lo = 1 << 30;
  logic prev_drv = 0;

  always @(negedge clk) begin
    if (valid) begin
      if (exp_q.size() == 0) check("R3 unexpected byte", int'(data), -1);
      else check("R3 byte value", int'(data), int'(exp_q.pop_front()));
    end
    if (busy) busy_seen = 1;
    if (scl_drv == prev_drv) run_len++;
    else begin
      if (!prev_drv) min_hi = (run_len < min_hi) ? run_len : min_hi;
      else           min_lo = (run_len < min_lo) ? run_len : min_lo;
      run_len = 1;
    end
    prev_drv = scl_drv;
  end

  task automatic clear_stats();
    n_start = 0; n_stop = 0; n_mack = 0; n_mnack = 0; n_fall = 0;
    n_ctl_wr = 0; n_ctl_rd = 0; addr_seen = -1; busy_seen = 0;
    min_hi = 1 << 30; min_lo = 1 << 30;
  endtask

  task automatic run_xfer(int cnt, bit with_data, bit poke_busy);
    clear_stats();
    exp_q.delete();
    if (with_data) for (int i = 0; i < cnt; i++) exp_q.push_back(mem_byte(i));
    @(negedge clk); start = 1; count = 8'(cnt);
    @(negedge clk); start = 0;
    if (cnt != 0) check("R10 busy after start", int'(busy), 1);
    if (poke_busy) begin
      repeat (300) @(negedge clk);
      start = 1; count = 8'd7;
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    check("R10 busy low at done", int'(busy), 0);
    repeat (2) @(negedge clk);
    check("R11 scl released", int'(scl_drv), 0);
    check("R11 sda released", int'(sda_drv), 0);
    check("R10 done held", int'(done), 1);
    check("R3 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 scl drive in reset", int'(scl_drv), 0);
    check("R1 sda drive in reset", int'(sda_drv), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 err in reset", int'(err), 0);
    check("R1 valid in reset", int'(valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: empty transfer
    run_xfer(0, 0, 0);
    check("R2 err", int'(err), 0);
    check("R2 no scl edge", n_fall, 0);
    check("R2 never busy", int'(busy_seen), 0);

    // R3 R4 R7 R9: single byte
    run_xfer(1, 1, 0);
    check("R3 err", int'(err), 0);
    check("R3 write select seen", n_ctl_wr, 1);
    check("R3 word address", addr_seen, 0);
    check("R3 read select seen", n_ctl_rd, 1);
    check("R4 starts", n_start, 2);
    check("R4 stops", n_stop, 1);
    check("R7 acks", n_mack, 0);
    check("R7 final nack", n_mnack, 1);
    check("R9 scl high cycles", min_hi, DIV);
    check("R9 scl low cycles", min_lo, 2 * DIV);

    // R7 R10: five bytes, second start ignored
    run_xfer(5, 1, 1);
    check("R10 ignored start err", int'(err), 0);
    check("R10 single transaction", n_start, 2);
    check("R7 acks", n_mack, 4);
    check("R7 final nack", n_mnack, 1);

    // R5: stuck data line before start
    jam = 3;
    run_xfer(2, 1, 0);
    check("R5 recovered after 3", int'(err), 0);
    jam = 10;
    run_xfer(2, 1, 0);
    check("R5 recovered after 10", int'(err), 0);
    jam = 11;
    run_xfer(2, 0, 0);
    check("R5 gives up err", int'(err), 1);
    check("R5 pulses issued", n_fall, 10);
    jam = 0;
    repeat (4) @(negedge clk);

    // R6: missing acknowledge on each transmitted byte
    for (int k = 1; k <= 3; k++) begin
      nack_ctl = k;
      run_xfer(3, 0, 0);
      check("R6 no ack err", int'(err), 1);
    end
    nack_ctl = 0;

    // R8: stop retries
    stop_jam = 9;
    run_xfer(2, 1, 0);
    check("R8 stop ok on tenth try", int'(err), 0);
    stop_jam = 10;
    run_xfer(2, 1, 0);
    check("R8 stop fails after ten", int'(err), 1);
    stop_jam = 0; jam = 0;
    repeat (4) @(negedge clk);

    // R3: longer run
    run_xfer(20, 1, 0);
    check("R3 long run err", int'(err), 0);
    check("R7 long run acks", n_mack, 19);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule